// File: doc/BRIEF.md
# Display Controller Sticky Status Register

This block gathers event pulses from around a display controller and holds them in a 32-bit status word. The sources are the frame-fetch DMA, the AC-bias toggle counter, the controller's shutdown sequencer, and the input and output pixel FIFOs of both panels. Most flags are sticky. Each one latches on a single-cycle event pulse and stays set until software writes a 1 to its position. Writing a 0 leaves a flag alone.

One flag is read-only and follows live hardware state. It tracks whether a newly written frame base address has been copied into the current-address pointer. A single shared error mask gates the error flags onto one registered interrupt request line. Software reads the whole word at any time through `rd_data`, and writes clear-masks through `wr_en`/`wr_data`.

Top module: `disp_stat_reg`

## Requirements
- R1: After reset every bit of `rd_data` is 0 and `irq` is 0.
- R2: The bit positions in `rd_data` are fixed, and the mapping of each input to its bit is:

  | `rd_data` bit | Meaning | Driven by |
  |---|---|---|
  | 0 | Shutdown finished (the controller was disabled and its last frame ended) | `disable_done_evt` |
  | 1 | Base address transferred | base-tracking logic (read-only) |
  | 2 | DMA bus error (an access to reserved or absent memory, which returns zero data) | `bus_err_evt` |
  | 3 | AC-bias count reached | `bias_cnt_evt` |
  | 4 to 11 | FIFO error flags | `fifo_err_evt[0]` to `fifo_err_evt[7]` |

  Within the FIFO flags, `fifo_err_evt` bits 0 to 7 mean, in order: input overrun lower, input underrun lower, input overrun upper, input underrun upper, output overrun lower, output underrun lower, output overrun upper, output underrun upper. An output underrun is the case where the FIFO is completely empty and the pin driver tries to fetch from it.
- R3: An event pulse sampled on a clock edge sets its sticky bit, which reads 1 from that edge on and stays set while no clear is written.
- R4: A write with `wr_data` bit i = 1 clears sticky bit i at that edge. A write with bit i = 0 leaves bit i unchanged.
- R5: If an event and a write-1 clear reach the same sticky bit on the same edge, the bit ends up set.
- R6: Bits 31:12 of `rd_data` always read 0, and writes to them have no effect.
- R7: Bit 1 ignores register writes. `base_load` drives it to 0 and `base_xfer` drives it to 1. If both arrive on the same edge, the bit ends at 1.
- R8: `irq` is 1 in the cycle after an edge at which `err_mask` was 0 and any of bits 2 or 4 to 11 was set. It stays asserted while that condition holds.
- R9: `irq` is 0 in the cycle after an edge at which `err_mask` was 1. Bits 0, 1 and 3 never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; 1 bits clear sticky flags |
| rd_data | output | 32 | Current status word |
| err_mask | input | 1 | 1 blocks the interrupt request |
| disable_done_evt | input | 1 | Pulse: the controller was shut down and its last frame ended |
| bus_err_evt | input | 1 | Pulse: the DMA accessed reserved or absent memory |
| bias_cnt_evt | input | 1 | Pulse: the AC-bias toggle counter reached zero |
| fifo_err_evt | input | 8 | Pulses for the FIFO overrun and underrun errors, in the order given in R2 |
| base_load | input | 1 | Pulse: software wrote a new frame base address |
| base_xfer | input | 1 | Pulse: the base was copied into the current-address pointer |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first is a hardware event and a software clear on one sticky bit. The second is a base load and a base transfer on the read-only flag. The bench drives each collision directly on every bit and also lets them happen by chance during a long pseudo-random stretch. A behavioural model gives the expected result of each collision: set wins on the sticky bit, and transfer wins on the base flag. The model is compared with `rd_data` and `irq` after every clock edge.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;
  localparam int unsigned BIT_DIS_DONE = 0;
  localparam int unsigned BIT_BASE_UPD = 1;
  localparam int unsigned BIT_BUS_ERR  = 2;
  localparam int unsigned BIT_BIAS_CNT = 3;
  localparam int unsigned BIT_FIFO_LO  = 4;
  localparam int unsigned FIXED_FLAGS  = 4;
  // Within the fixed group: sticky bits 0,2,3; error bits only 2.
  localparam logic [FIXED_FLAGS-1:0] FIXED_STICKY = 4'b1101;
  localparam logic [FIXED_FLAGS-1:0] FIXED_ERR    = 4'b0100;
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/disp_sticky_flag.sv
module disp_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_pulse | clr_req;
    flag_d  = set_pulse ? 1'b1 : 1'b0;   // set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag);
  p_set_beats_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse && clr_req) |=> flag);
  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_pulse) |=> !flag);
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_pulse) |=> $stable(flag));
endmodule

// File: rtl/disp_base_track.sv
module disp_base_track (
  input  logic clk,
  input  logic rst_n,
  input  logic base_load,
  input  logic base_xfer,
  output logic xfer_done
);
  logic done_q;
  logic done_d;
  logic done_en;

  always_comb begin
    done_en = base_load | base_xfer;
    done_d  = base_xfer;                 // transfer beats a fresh load
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  assign xfer_done = done_q;

  p_xfer_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    base_xfer |=> xfer_done);
  p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base_load && !base_xfer) |=> !xfer_done);
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_load && !base_xfer) |=> $stable(xfer_done));
endmodule

// File: rtl/disp_irq_gen.sv
module disp_irq_gen #(
  parameter int unsigned NUM_FLAGS = 12,
  parameter logic [NUM_FLAGS-1:0] ERR_SEL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] status,
  input  logic                 err_mask,
  output logic                 irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = !err_mask && (|(status & ERR_SEL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_mask && (|(status & ERR_SEL))) |=> irq);
  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_mask |=> !irq);
  p_no_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & ERR_SEL)) |=> !irq);
endmodule

// File: rtl/disp_stat_reg.sv
module disp_stat_reg
  import disp_stat_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned FIFO_EVT_W = 8,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  err_mask,
  input  logic                  disable_done_evt,
  input  logic                  bus_err_evt,
  input  logic                  bias_cnt_evt,
  input  logic [FIFO_EVT_W-1:0] fifo_err_evt,
  input  logic                  base_load,
  input  logic                  base_xfer,
  output logic                  irq
);
  localparam int unsigned NUM_FLAGS = FIXED_FLAGS + FIFO_EVT_W;
  localparam int unsigned RSVD_W    = REG_W - NUM_FLAGS;
  localparam logic [NUM_FLAGS-1:0] STICKY_SEL = {{FIFO_EVT_W{1'b1}}, FIXED_STICKY};
  localparam logic [NUM_FLAGS-1:0] ERR_SEL    = {{FIFO_EVT_W{1'b1}}, FIXED_ERR};

  logic                 rst_n_s;
  logic [NUM_FLAGS-1:0] evt_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] stat;

  disp_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    evt_vec                           = '0;
    evt_vec[BIT_DIS_DONE]             = disable_done_evt;
    evt_vec[BIT_BUS_ERR]              = bus_err_evt;
    evt_vec[BIT_BIAS_CNT]             = bias_cnt_evt;
    evt_vec[NUM_FLAGS-1:BIT_FIFO_LO]  = fifo_err_evt;
    clr_vec = wr_en ? wr_data[NUM_FLAGS-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (STICKY_SEL[i]) begin : g_sticky
      disp_sticky_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .set_pulse (evt_vec[i]),
        .clr_req   (clr_vec[i]),
        .flag      (stat[i])
      );
    end
  end

  disp_base_track u_base (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .base_load (base_load),
    .base_xfer (base_xfer),
    .xfer_done (stat[BIT_BASE_UPD])
  );

  disp_irq_gen #(.NUM_FLAGS(NUM_FLAGS), .ERR_SEL(ERR_SEL)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .status   (stat),
    .err_mask (err_mask),
    .irq      (irq)
  );

  assign rd_data = {{RSVD_W{1'b0}}, stat};

  // R7: software writes never move the read-only bit
  p_ro_ignores_write_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !base_load && !base_xfer) |=> $stable(rd_data[BIT_BASE_UPD]));
  // R6: reserved field stays clear after any write
  p_rsvd_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en |=> (rd_data[REG_W-1:NUM_FLAGS] == '0));
endmodule

// File: tb/disp_stat_reg_tb.sv
`timescale 1ns/1ps
module disp_stat_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        err_mask;
  logic        disable_done_evt, bus_err_evt, bias_cnt_evt;
  logic [7:0]  fifo_err_evt;
  logic        base_load, base_xfer;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic [31:0] m_stat = '0;
  logic        m_irq  = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  disp_stat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .err_mask(err_mask),
    .disable_done_evt(disable_done_evt), .bus_err_evt(bus_err_evt),
    .bias_cnt_evt(bias_cnt_evt), .fifo_err_evt(fifo_err_evt),
    .base_load(base_load), .base_xfer(base_xfer), .irq(irq)
  );

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; disable_done_evt = 0; bus_err_evt = 0;
    bias_cnt_evt = 0; fifo_err_evt = '0; base_load = 0; base_xfer = 0;
  endtask

  // Drive a 12-bit event pattern in the bit order of R2 (bit 1 unused).
  task automatic set_events(input logic [11:0] ev);
    disable_done_evt = ev[0]; bus_err_evt = ev[2]; bias_cnt_evt = ev[3];
    fifo_err_evt = ev[11:4];
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: model update at the edge, comparison at the falling edge.
  task automatic step();
    logic [31:0] nxt;
    logic        nirq;
    @(posedge clk);
    nxt  = m_stat;
    nirq = !err_mask && ((m_stat & 32'h0000_0FF4) != 0);
    for (int i = 0; i < 12; i++) begin
      if (i == 1) continue;
      if (wr_en && wr_data[i]) nxt[i] = 1'b0;
    end
    if (disable_done_evt) nxt[0] = 1'b1;
    if (bus_err_evt)      nxt[2] = 1'b1;
    if (bias_cnt_evt)     nxt[3] = 1'b1;
    for (int k = 0; k < 8; k++) if (fifo_err_evt[k]) nxt[4+k] = 1'b1;
    if (base_load) nxt[1] = 1'b0;
    if (base_xfer) nxt[1] = 1'b1;
    m_stat = nxt;
    m_irq  = nirq;
    @(negedge clk);
    check(cur_req, rd_data, m_stat);
    check({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    idle_inputs();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; err_mask = 1'b0; idle_inputs();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", rd_data, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (4) step();

    // R2/R3/R4: each sticky bit alone lands at its position, then clears
    for (int i = 0; i < 12; i++) begin
      if (i == 1) continue;
      cur_req = "R3";
      set_events(12'(1) << i); step();
      check("R2 position", rd_data, 32'(1) << i);
      step();                                  // held, irq may rise
      cur_req = "R4";
      wr_en = 1; wr_data = '0; step();         // write 0: no effect
      wr_en = 1; wr_data = 32'(1) << i; step();
      step();
    end

    // R6: writes to reserved bits, and all-ones clear
    cur_req = "R6";
    set_events(12'hFFD); step();
    wr_en = 1; wr_data = 32'hFFFF_F000; step();
    check("R6 reserved", rd_data & 32'hFFFF_F000, 32'd0);
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
    step();

    // R5: set and clear collide on every sticky bit
    cur_req = "R5";
    set_events(12'hFFD); wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
    check("R5 collide", rd_data, 32'h0000_0FFD);
    wr_en = 1; wr_data = 32'h0000_0FFF; step();
    step();

    // R7: read-only base flag
    cur_req = "R7";
    base_xfer = 1; step();
    wr_en = 1; wr_data = 32'h2; step();
    check("R7 ro", rd_data & 32'h2, 32'h2);
    base_load = 1; step();
    base_load = 1; base_xfer = 1; step();
    check("R7 both", rd_data & 32'h2, 32'h2);
    base_load = 1; step();

    // R8/R9: mask gating and non-error bits
    cur_req = "R9";
    set_events(12'h009); step(); step(); step();   // bits 0,3 only
    check("R9 no irq", {31'd0, irq}, 32'd0);
    cur_req = "R8";
    bus_err_evt = 1; step(); step(); step();
    err_mask = 1; cur_req = "R9"; step(); step();
    err_mask = 0; cur_req = "R8"; step(); step();
    wr_en = 1; wr_data = 32'hFFF; step(); step(); step();

    // Mixed pseudo-random traffic against the model (R3..R9)
    cur_req = "R5 mix";
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      set_events(lfsr[11:0] & lfsr[23:12] & 12'hFFD);
      wr_en = lfsr[24];
      wr_data = {lfsr[7:0], lfsr[31:8]};
      base_load = lfsr[25] & lfsr[26];
      base_xfer = lfsr[27] & lfsr[28];
      err_mask = lfsr[29] & lfsr[30] & lfsr[31];
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule